// File: doc/BRIEF.md
# Debug Bus Read Engine

This block lets an external debugger read 64-bit words from system memory without halting anything. It sits on the debug register bus and exposes four registers through a simple access port: a control/status word, an address register and two 32-bit data words. A write to the address register starts a bus read at that address, as long as the control word permits it. The block drives a memory master port with a request/grant handshake followed by a response whose latency varies. The returned 64-bit word is split across the two data registers.

Only one access can be in flight. While it runs, the status word shows busy. If software touches the address or data registers before the access finishes, the block records a sticky busy-error flag. That flag stops any new access until software clears it. Refused requests and failed bus responses are reported through a 3-bit error field, which software clears by writing ones to it.

Top module: `sbReadEngine`

## Requirements
- R1: After reset the control/status word, address and both data registers read 0, and memReq is low.
- R2: Register offsets are control/status 0x38, address 0x39, data-low 0x3C and data-high 0x3D. In the control/status word, bit 22 is busy-error, bit 21 is busy, bit 20 is read-on-address, bits [19:17] are the access size and bits [14:12] are the error field. Read-on-address and size read back as written. Any other offset reads 0.
- R3: A write to 0x39 with read-on-address=1, size=3, write data bits [2:0]=0, busy=0 and busy-error=0 stores the address and starts one bus request for it. Busy reads 1 from the next cycle.
- R4: When a good response returns, data-low takes result bits [31:0] and data-high takes bits [63:32], and busy clears on the same clock edge.
- R5: With read-on-address=0, an address write only stores the address and starts no request.
- R6: An address write with bits [2:0] not zero is refused: there is no request, busy stays 0 and the error field becomes 3.
- R7: An address write while size is not 3 is refused: there is no request and the error field becomes 4.
- R8: An address write or a data-register read while busy sets busy-error. The stored address is left unchanged and the running access completes normally.
- R9: Writing 1 to bit 22 clears busy-error. Writing 0 there leaves it set.
- R10: While busy-error is set, an address write starts no request.
- R11: An error response sets the error field to 7, leaves the data registers unchanged and clears busy. Writing ones to bits [14:12] clears the field.
- R12: memReq stays high with a stable memAddr until memGnt is seen, and each started read produces exactly one granted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 7 | Register offset |
| regWdata | input | 32 | Register write data |
| regWe | input | 1 | Register write enable |
| regRe | input | 1 | Register read enable (data reads have a side effect) |
| regRdata | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memGnt | input | 1 | Request accepted |
| memRvalid | input | 1 | Response valid |
| memRdata | input | 64 | Response data |
| memRerr | input | 1 | Response carries an error |

## Verification
A memory response and a register access can land on the same clock edge. The case of interest is a data-register read arriving in exactly the cycle the response completes the access. The bench pins the memory model to zero grant delay and zero latency, then issues the read so that it reaches that edge. The read must count as a collision, because busy is still 1 before the edge, so busy-error must be set. The response must still be captured, and busy must read 0 afterwards.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int RegAW = 7;
  localparam int WordW = 32;
  localparam int BeatW = 2 * WordW;

  localparam logic [RegAW-1:0] OffCsr   = 7'h38;
  localparam logic [RegAW-1:0] OffAddr  = 7'h39;
  localparam logic [RegAW-1:0] OffData0 = 7'h3C;
  localparam logic [RegAW-1:0] OffData1 = 7'h3D;

  localparam int BitBusyErr = 22;
  localparam int BitBusy    = 21;
  localparam int BitRoa     = 20;
  localparam int SizeLo     = 17;
  localparam int ErrLo      = 12;

  localparam logic [2:0] Size64   = 3'd3;
  localparam logic [2:0] ErrAlign = 3'd3;
  localparam logic [2:0] ErrSize  = 3'd4;
  localparam logic [2:0] ErrBus   = 3'd7;

  typedef enum logic [1:0] {StIdle, StReq, StWait} engState_e;

  typedef struct packed {
    logic latchAddr;
    logic collide;
    logic alignErr;
    logic sizeErr;
    logic capture;
    logic busErr;
  } strobe_t;
endpackage

// File: rtl/sbrCtrl.sv
module sbrCtrl
  import sbr_pkg::*;
#(
  parameter int AlignBits = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [RegAW-1:0]     regAddr,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [AlignBits-1:0] wLow,
  input  logic                 readOnAddr,
  input  logic [2:0]           accSize,
  input  logic                 busyErr,
  input  logic                 memGnt,
  input  logic                 memRvalid,
  input  logic                 memRerr,
  output logic                 memReq,
  output logic                 busy,
  output strobe_t              strb
);
  engState_e state, stateNext;
  logic addrWr, dataRd, go, aligned, startRead, respIn;

  assign addrWr  = regWe && (regAddr == OffAddr);
  assign dataRd  = regRe && ((regAddr == OffData0) || (regAddr == OffData1));
  assign aligned = (wLow == '0);
  assign busy    = (state != StIdle);
  assign memReq  = (state == StReq);
  assign respIn  = (state == StWait) && memRvalid;

  assign go        = addrWr && !busy && readOnAddr && !busyErr;
  assign startRead = go && (accSize == Size64) && aligned;

  always_comb begin
    strb           = '0;
    strb.latchAddr = addrWr && !busy;
    strb.collide   = busy && (addrWr || dataRd);
    strb.sizeErr   = go && (accSize != Size64);
    strb.alignErr  = go && (accSize == Size64) && !aligned;
    strb.capture   = respIn && !memRerr;
    strb.busErr    = respIn && memRerr;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      StIdle:  if (startRead) stateNext = StReq;
      StReq:   if (memGnt) stateNext = StWait;
      StWait:  if (memRvalid) stateNext = StIdle;
      default: stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  // R6
  misaligned_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrWr && !busy && (wLow != '0)) |=> !busy);
  // R10
  busyerr_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyErr && !busy) |=> !busy);
  // R4
  resp_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRvalid && busy && !memReq) |=> !busy);
endmodule

// File: rtl/sbrData.sv
module sbrData
  import sbr_pkg::*;
#(
  parameter int AddrW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RegAW-1:0] regAddr,
  input  logic             regWe,
  input  logic [WordW-1:0] regWdata,
  input  logic             busy,
  input  strobe_t          strb,
  input  logic [BeatW-1:0] memRdata,
  output logic             readOnAddr,
  output logic [2:0]       accSize,
  output logic             busyErr,
  output logic [AddrW-1:0] memAddr,
  output logic [WordW-1:0] regRdata
);
  logic [AddrW-1:0] addrQ;
  logic [BeatW-1:0] dataQ;
  logic [2:0]       errQ;
  logic             csrWr;
  logic [WordW-1:0] csrView;

  assign csrWr   = regWe && (regAddr == OffCsr);
  assign memAddr = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readOnAddr <= 1'b0;
      accSize    <= '0;
      busyErr    <= 1'b0;
      errQ       <= '0;
    end else begin
      if (csrWr) begin
        readOnAddr <= regWdata[BitRoa];
        accSize    <= regWdata[SizeLo +: 3];
        if (regWdata[BitBusyErr]) busyErr <= 1'b0;
      end
      if (strb.collide) busyErr <= 1'b1;
      if (strb.busErr)        errQ <= ErrBus;
      else if (strb.alignErr) errQ <= ErrAlign;
      else if (strb.sizeErr)  errQ <= ErrSize;
      else if (csrWr)         errQ <= errQ & ~regWdata[ErrLo +: 3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strb.latchAddr) addrQ <= regWdata[AddrW-1:0];
      if (strb.capture)   dataQ <= memRdata;
    end
  end

  always_comb begin
    csrView             = '0;
    csrView[BitBusyErr] = busyErr;
    csrView[BitBusy]    = busy;
    csrView[BitRoa]     = readOnAddr;
    csrView[SizeLo +: 3] = accSize;
    csrView[ErrLo +: 3]  = errQ;
  end

  always_comb begin
    unique case (regAddr)
      OffCsr:   regRdata = csrView;
      OffAddr:  regRdata = WordW'(addrQ);
      OffData0: regRdata = dataQ[WordW-1:0];
      OffData1: regRdata = dataQ[BeatW-1:WordW];
      default:  regRdata = '0;
    endcase
  end

  // R8
  collide_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.collide |=> busyErr);
  // R8
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrQ));
  // R11
  bus_error_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busErr |=> (errQ == ErrBus) && $stable(dataQ));
  // R4
  capture_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (dataQ == $past(memRdata)));
endmodule

// File: rtl/sbReadEngine.sv
module sbReadEngine
  import sbr_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int AlignBits = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [6:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             regWe,
  input  logic             regRe,
  output logic [31:0]      regRdata,
  output logic             memReq,
  output logic [AddrW-1:0] memAddr,
  input  logic             memGnt,
  input  logic             memRvalid,
  input  logic [63:0]      memRdata,
  input  logic             memRerr
);
  strobe_t    strb;
  logic       busy, readOnAddr, busyErr;
  logic [2:0] accSize;

  sbrCtrl #(.AlignBits(AlignBits)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .wLow(regWdata[AlignBits-1:0]), .readOnAddr(readOnAddr), .accSize(accSize),
    .busyErr(busyErr), .memGnt(memGnt), .memRvalid(memRvalid), .memRerr(memRerr),
    .memReq(memReq), .busy(busy), .strb(strb)
  );

  sbrData #(.AddrW(AddrW)) uData (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .busy(busy), .strb(strb), .memRdata(memRdata), .readOnAddr(readOnAddr),
    .accSize(accSize), .busyErr(busyErr), .memAddr(memAddr), .regRdata(regRdata)
  );

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));
endmodule

// File: tb/sim_sbReadEngine.sv
module sim_sbReadEngine;
  localparam int ClkPeriod = 10;
  localparam logic [6:0] ACsr = 7'h38, AAddr = 7'h39, AD0 = 7'h3C, AD1 = 7'h3D;
  localparam logic [31:0] Cfg = 32'h0016_0000;

  logic clk = 0, rstN = 0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata, memAddr;
  logic regWe = 0, regRe = 0, memReq, memGnt = 0, memRvalid = 0, memRerr = 0;
  logic [63:0] memRdata = '0;

  int vectors = 0, misses = 0, fixGnt = -1, fixLat = -1;
  logic errNext = 0;
  bit done = 0;
  logic [31:0] expQ[$];

  always #(ClkPeriod/2) clk = ~clk;

  sbReadEngine u0 (.*);

  function automatic logic [63:0] modelData(logic [31:0] a);
    return {a ^ 32'hDEAD_BEEF, ~a};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    regAddr = a; regRe = 1; #1 v = regRdata;
    @(negedge clk); regRe = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(ACsr, v);
      if (!v[21]) break;
    end
  endtask

  // memory model: random grant delay and latency unless pinned
  initial begin
    forever begin
      @(negedge clk); memGnt = 0; memRvalid = 0; memRerr = 0;
      if (memReq) begin
        repeat (fixGnt >= 0 ? fixGnt : $urandom_range(0, 3)) @(negedge clk);
        memGnt = 1;
        memRdata = modelData(memAddr);
        @(negedge clk); memGnt = 0;
        repeat (fixLat >= 0 ? fixLat : $urandom_range(0, 5)) @(negedge clk);
        memRvalid = 1; memRerr = errNext;
      end
    end
  end

  // monitor: every granted request must match the next expected address
  initial begin
    forever begin
      @(negedge clk); #2;
      if (memReq && memGnt) begin
        if (expQ.size() == 0) check("R12 unexpected request", memAddr, 32'hxxxx_xxxx);
        else check("R3 request address", memAddr, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, a2;
    logic [63:0] last;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rd(ACsr, v); check("R1 csr", v, 0);
    rd(AAddr, v); check("R1 addr", v, 0);
    rd(AD0, v); check("R1 data0", v, 0);
    rd(AD1, v); check("R1 data1", v, 0);
    check("R1 memReq", {31'b0, memReq}, 0);

    wr(ACsr, Cfg);
    rd(ACsr, v); check("R2 csr readback", v, Cfg);
    rd(7'h3A, v); check("R2 unmapped", v, 0);

    for (int i = 0; i < 6; i++) begin
      a = {$urandom_range(0, 32'h0FFF_FFFF), 3'b000};
      expQ.push_back(a);
      wr(AAddr, a);
      rd(ACsr, v); check("R3 busy set", v[21], 1);
      waitIdle();
      rd(AD0, v); check("R4 data low", v, modelData(a)[31:0]);
      rd(AD1, v); check("R4 data high", v, modelData(a)[63:32]);
      rd(AAddr, v); check("R3 addr stored", v, a);
      last = modelData(a);
    end

    wr(ACsr, 32'h0006_0000);
    wr(AAddr, 32'h0000_1230);
    repeat (8) @(negedge clk);
    rd(ACsr, v); check("R5 no access", v, 32'h0006_0000);
    rd(AAddr, v); check("R5 addr stored", v, 32'h0000_1230);

    wr(ACsr, Cfg);
    wr(AAddr, 32'h0000_2004);
    repeat (4) @(negedge clk);
    rd(ACsr, v); check("R6 misaligned", v, Cfg | (3 << 12));
    wr(ACsr, Cfg | (7 << 12));
    rd(ACsr, v); check("R11 err clear", v, Cfg);

    wr(ACsr, 32'h0014_0000);
    wr(AAddr, 32'h0000_3000);
    repeat (4) @(negedge clk);
    rd(ACsr, v); check("R7 size refused", v, 32'h0014_0000 | (4 << 12));
    wr(ACsr, Cfg | (7 << 12));

    fixGnt = 0; fixLat = 8;
    a = 32'h0000_4008; a2 = 32'h0000_5010;
    expQ.push_back(a);
    wr(AAddr, a);
    wr(AAddr, a2);
    waitIdle();
    rd(AAddr, v); check("R8 addr kept", v, a);
    rd(AD1, v); check("R8 access completed", v, modelData(a)[63:32]);
    rd(ACsr, v); check("R8 busy-error set", v, Cfg | (1 << 22));
    wr(AAddr, 32'h0000_6000);
    repeat (12) @(negedge clk);
    rd(ACsr, v); check("R10 blocked", v[21], 0);
    wr(ACsr, Cfg);
    rd(ACsr, v); check("R9 zero keeps", v, Cfg | (1 << 22));
    wr(ACsr, Cfg | (1 << 22));
    rd(ACsr, v); check("R9 cleared", v, Cfg);

    fixGnt = 0; fixLat = 0;
    a = 32'h0000_7788;
    expQ.push_back(a);
    wr(AAddr, a);
    @(negedge clk);
    rd(AD0, v);
    rd(ACsr, v); check("R8 same-cycle collide", v, Cfg | (1 << 22));
    rd(AD0, v); check("R4 same-cycle capture", v, modelData(a)[31:0]);
    wr(ACsr, Cfg | (1 << 22));
    last = modelData(a);

    fixGnt = -1; fixLat = -1; errNext = 1;
    expQ.push_back(32'h0000_9000);
    wr(AAddr, 32'h0000_9000);
    waitIdle();
    errNext = 0;
    rd(ACsr, v); check("R11 bus error", v, Cfg | (7 << 12));
    rd(AD1, v); check("R11 data kept", v, last[63:32]);
    wr(ACsr, Cfg | (7 << 12));
    rd(ACsr, v); check("R11 cleared", v, Cfg);

    repeat (10) @(negedge clk);
    check("R12 all requests seen", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule